// File: doc/BRIEF.md
# Memory Access Fault Classifier

This block decides, for a single memory access that has already been looked up in a translation cache, whether the access may proceed or which abort it raises. It takes the access attributes (address, kind, privilege, alignment requirement, prefetch hint), the translation control bits, the 32-bit per-domain access word and the fields of the matching cache entry. One cycle later it presents a registered verdict. The verdict is one of three things: no fault, a fault code tagged as either an instruction-side (prefetch) abort or a data abort, or an unpredictable-configuration error.

The checks run in a fixed priority. The alignment check comes first. Next is the translation-off bypass. Then come the miss handling and the prefetch restrictions. After those the per-domain gate is applied, and last the access-permission decode together with the execute-never check on fetches. Section and page entries get distinct fault codes for the domain fault and for the permission fault. Cache storage and table walking live elsewhere. When a non-prefetch access misses, the block flags that a walk is needed and raises no fault.

Top module: `mmu_access_checker`

## Requirements
- R1: `rsp_valid` equals `req_valid` of the previous clock. Synchronous reset clears `rsp_valid` and `rsp_fault`, and sets `rsp_code` to 0.
- R2: A non-fetch access faults with code 1 (alignment) as a data abort (`rsp_pabt`=0) when `align_chk` is 1 or `allow_unal` is 0 and the low address bits overlap `align_mask`. This check outranks every other check, including the translation-off bypass.
- R3: With `mmu_en`=0 and no alignment fault, there is no fault, no miss and no error, and `rsp_paddr` equals `vaddr`. With `mmu_en`=1, `rsp_paddr` equals `ent_paddr`.
- R4: With translation on and `tlb_hit`=0, a request with `prefetch`=1 gets code 6 (prefetch miss) as a prefetch abort. Any other request gets `rsp_miss`=1 and no fault.
- R5: A hit by a prefetch request on an entry with `ent_nocache`=1 gets code 7 as a prefetch abort. This takes priority over the domain check.
- R6: The domain field is `dacr[2*ent_dom+1 : 2*ent_dom]`. A field value of 0 faults with code 2 for a section entry (`ent_section`=1) or code 3 for a page entry. The fault is a prefetch abort for fetches (`kind`=2) and a data abort otherwise.
- R7: A domain field value of 3 grants the access whatever the AP and XN bits hold.
- R8: A domain field value of 2 raises `rsp_unpred` with code 0 and no fault.
- R9: When `afe` is 1, bit 0 of the entry AP is forced to 1 before decoding. AP 0 therefore behaves as AP 1, and AP 4 behaves as AP 5.
- R10: Under domain value 1 the AP bits decide the abort. AP 0 with `xperm`=0 aborts writes only when `rom_sys`=2, aborts writes and unprivileged accesses when `rom_sys`=1, and always aborts when `rom_sys` is 0 or 3. AP 0 with `xperm`=1 always aborts. AP 1 aborts unprivileged accesses. AP 2 aborts unprivileged writes. AP 3 never aborts. AP 5 aborts unprivileged accesses and all writes. AP 6 and AP 7 abort writes. The kind encoding is 0 read, 1 write, 2 fetch, and 3 is treated as a read.
- R11: An access is privileged only when `priv_mode` is 1 and `user_req` is 0.
- R12: A permission fault has code 4 for a section entry and 5 for a page entry. A fetch also faults when `ent_xn` is 1 and is reported as a prefetch abort. A non-fetch permission fault is a data abort.
- R13: An effective AP of 4 under domain value 1 raises `rsp_unpred` with code 0 and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| vaddr | input | 32 | Virtual address |
| kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| priv_mode | input | 1 | Processor in a privileged mode |
| user_req | input | 1 | Request forces unprivileged treatment |
| allow_unal | input | 1 | Request tolerates misalignment |
| align_mask | input | 3 | Size alignment mask over low address bits |
| prefetch | input | 1 | Request is a prefetch hint |
| mmu_en | input | 1 | Translation enable |
| align_chk | input | 1 | Strict alignment checking |
| afe | input | 1 | Access-flag enable (force AP bit 0) |
| xperm | input | 1 | Extended permission mode |
| rom_sys | input | 2 | Legacy ROM/system select for AP 0 |
| dacr | input | 32 | Two bits of access control per domain |
| tlb_hit | input | 1 | Matching entry found |
| ent_dom | input | 4 | Entry domain number |
| ent_ap | input | 3 | Entry access permission bits |
| ent_xn | input | 1 | Entry execute-never |
| ent_section | input | 1 | 1 section entry, 0 page entry |
| ent_nocache | input | 1 | Entry is non-cacheable |
| ent_paddr | input | 32 | Translated address from the entry |
| rsp_valid | output | 1 | Verdict present |
| rsp_fault | output | 1 | Access aborts |
| rsp_code | output | 3 | 0 none, 1 align, 2/3 domain sec/page, 4/5 perm sec/page, 6 prefetch miss, 7 prefetch uncached |
| rsp_pabt | output | 1 | 1 prefetch abort, 0 data abort |
| rsp_unpred | output | 1 | Unpredictable configuration hit |
| rsp_miss | output | 1 | Walk needed |
| rsp_paddr | output | 32 | Physical address |

## Verification
The permission decode is covered by a full sweep. Every raw AP value is combined with both access-flag settings, both extended-mode settings, all four ROM/system selects, all three access kinds and all four privilege/override pairs, with execute-never and the section flag varied. This separates the AP 0 legacy branches from one another, shows that forcing bit 0 moves AP 4 out of the unpredictable case, and exposes any swap between the privilege and user-override inputs. A second sweep walks every domain number through all four field values, so that a wrong bit position in the access word shows up as a wrong verdict. A third sweep crosses address low bits, alignment masks and the strictness controls, with translation both on and off, to confirm that the alignment check ranks above the bypass. Directed cases cover the miss and prefetch priorities, plus the valid/reset behaviour.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ALIGN    = 3'd1,
    FC_DOM_SEC  = 3'd2,
    FC_DOM_PAGE = 3'd3,
    FC_PRM_SEC  = 3'd4,
    FC_PRM_PAGE = 3'd5,
    FC_PF_MISS  = 3'd6,
    FC_PF_NC    = 3'd7
  } fault_code_e;

  typedef enum logic [1:0] {
    DOM_BLOCK  = 2'd0,
    DOM_CLIENT = 2'd1,
    DOM_RSVD   = 2'd2,
    DOM_MGR    = 2'd3
  } dom_mode_e;

  typedef struct packed {
    logic        fault;
    fault_code_e code;
    logic        pabt;
    logic        unpred;
    logic        miss;
  } verdict_t;

endpackage

// File: rtl/mmu_align_check.sv
module mmu_align_check #(
  parameter int MASK_W = 3
) (
  input  logic              is_fetch,
  input  logic              strict,
  input  logic              allow_unal,
  input  logic [MASK_W-1:0] addr_lo,
  input  logic [MASK_W-1:0] mask,
  output logic              misaligned
);
  logic enforce;
  always_comb begin
    enforce    = strict | ~allow_unal;
    misaligned = ~is_fetch & enforce & (|(addr_lo & mask));
  end
endmodule

// File: rtl/mmu_domain_sel.sv
module mmu_domain_sel #(
  parameter int DOM_W = 4,
  localparam int NDOM = 1 << DOM_W,
  localparam int ACW  = 2 * NDOM
) (
  input  logic [ACW-1:0]   acw,
  input  logic [DOM_W-1:0] dom,
  output logic [1:0]       field
);
  logic [1:0] fields [NDOM];

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    assign fields[g] = acw[2*g +: 2];
  end

  assign field = fields[dom];
endmodule

// File: rtl/mmu_ap_decode.sv
module mmu_ap_decode (
  input  logic [2:0] ap_raw,
  input  logic       afe,
  input  logic       xperm,
  input  logic [1:0] rom_sys,
  input  logic       privileged,
  input  logic       is_write,
  output logic       abort,
  output logic       unpred
);
  logic [2:0] ap;
  logic       legacy_abort;

  always_comb begin
    ap = {ap_raw[2:1], ap_raw[0] | afe};

    // legacy AP 0 behaviour selected by the ROM/system pair
    unique case (rom_sys)
      2'd2:    legacy_abort = is_write;
      2'd1:    legacy_abort = is_write | ~privileged;
      default: legacy_abort = 1'b1;
    endcase

    unpred = 1'b0;
    abort  = 1'b1;
    if (ap[2]) begin
      if (ap[1]) abort = is_write;
      else if (ap[0]) abort = is_write | ~privileged;
      else begin
        unpred = 1'b1;
        abort  = 1'b0;
      end
    end else begin
      unique case (ap[1:0])
        2'd0: abort = xperm ? 1'b1 : legacy_abort;
        2'd1: abort = ~privileged;
        2'd2: abort = ~privileged & is_write;
        2'd3: abort = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mmu_access_checker.sv
module mmu_access_checker
  import mmu_chk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MASK_W = 3,
  parameter int DOM_W  = 4,
  localparam int ACW   = 2 * (1 << DOM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     vaddr,
  input  logic [1:0]        kind,
  input  logic              priv_mode,
  input  logic              user_req,
  input  logic              allow_unal,
  input  logic [MASK_W-1:0] align_mask,
  input  logic              prefetch,
  input  logic              mmu_en,
  input  logic              align_chk,
  input  logic              afe,
  input  logic              xperm,
  input  logic [1:0]        rom_sys,
  input  logic [ACW-1:0]    dacr,
  input  logic              tlb_hit,
  input  logic [DOM_W-1:0]  ent_dom,
  input  logic [2:0]        ent_ap,
  input  logic              ent_xn,
  input  logic              ent_section,
  input  logic              ent_nocache,
  input  logic [AW-1:0]     ent_paddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_code,
  output logic              rsp_pabt,
  output logic              rsp_unpred,
  output logic              rsp_miss,
  output logic [AW-1:0]     rsp_paddr
);
  logic       is_fetch, is_write, privileged;
  logic       misaligned, ap_abort, ap_unpred;
  logic [1:0] dom_field;
  verdict_t   vd;

  assign is_fetch   = (kind == KIND_FETCH);
  assign is_write   = (kind == KIND_WRITE);
  assign privileged = priv_mode & ~user_req;

  mmu_align_check #(.MASK_W(MASK_W)) u_align (
    .is_fetch   (is_fetch),
    .strict     (align_chk),
    .allow_unal (allow_unal),
    .addr_lo    (vaddr[MASK_W-1:0]),
    .mask       (align_mask),
    .misaligned (misaligned)
  );

  mmu_domain_sel #(.DOM_W(DOM_W)) u_dom (
    .acw   (dacr),
    .dom   (ent_dom),
    .field (dom_field)
  );

  mmu_ap_decode u_ap (
    .ap_raw     (ent_ap),
    .afe        (afe),
    .xperm      (xperm),
    .rom_sys    (rom_sys),
    .privileged (privileged),
    .is_write   (is_write),
    .abort      (ap_abort),
    .unpred     (ap_unpred)
  );

  // priority resolution of all checks
  always_comb begin
    vd = '{fault: 1'b0, code: FC_NONE, pabt: 1'b0, unpred: 1'b0, miss: 1'b0};
    if (misaligned) begin
      vd.code = FC_ALIGN;
    end else if (!mmu_en) begin
      vd.code = FC_NONE;
    end else if (!tlb_hit) begin
      if (prefetch) begin
        vd.code = FC_PF_MISS;
        vd.pabt = 1'b1;
      end else begin
        vd.miss = 1'b1;
      end
    end else if (prefetch && ent_nocache) begin
      vd.code = FC_PF_NC;
      vd.pabt = 1'b1;
    end else begin
      unique case (dom_mode_e'(dom_field))
        DOM_BLOCK: begin
          vd.code = ent_section ? FC_DOM_SEC : FC_DOM_PAGE;
          vd.pabt = is_fetch;
        end
        DOM_CLIENT: begin
          if (ap_unpred) begin
            vd.unpred = 1'b1;
          end else if (ap_abort || (is_fetch && ent_xn)) begin
            vd.code = ent_section ? FC_PRM_SEC : FC_PRM_PAGE;
            vd.pabt = is_fetch;
          end
        end
        DOM_RSVD: vd.unpred = 1'b1;
        DOM_MGR:  vd.code   = FC_NONE;
      endcase
    end
    vd.fault = (vd.code != FC_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_code   <= 3'd0;
      rsp_pabt   <= 1'b0;
      rsp_unpred <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault  <= vd.fault;
        rsp_code   <= vd.code;
        rsp_pabt   <= vd.pabt;
        rsp_unpred <= vd.unpred;
        rsp_miss   <= vd.miss;
        rsp_paddr  <= mmu_en ? ent_paddr : vaddr;
      end
    end
  end
endmodule

// File: rtl/mmu_access_checker_sva.sv
module mmu_access_checker_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    kind,
  input logic          mmu_en,
  input logic [AW-1:0] vaddr,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [2:0]    rsp_code,
  input logic          rsp_pabt,
  input logic          rsp_unpred,
  input logic [AW-1:0] rsp_paddr
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r2_align_is_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'd1) |-> !rsp_pabt);

  a_r3_bypass_fetch: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_en && kind == 2'd2) |=> (!rsp_fault && rsp_paddr == $past(vaddr)));

  a_r8_unpred_no_fault: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_unpred) |-> (!rsp_fault && rsp_code == 3'd0));

  a_r12_fault_has_code: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));
endmodule

bind mmu_access_checker mmu_access_checker_sva #(.AW(AW)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .kind       (kind),
  .mmu_en     (mmu_en),
  .vaddr      (vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_code   (rsp_code),
  .rsp_pabt   (rsp_pabt),
  .rsp_unpred (rsp_unpred),
  .rsp_paddr  (rsp_paddr)
);

// File: tb/mmu_access_checker_tb.sv
module mmu_access_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  kind = '0;
  logic        priv_mode = 1'b1, user_req = 1'b0, allow_unal = 1'b1;
  logic [2:0]  align_mask = '0;
  logic        prefetch = 1'b0, mmu_en = 1'b1, align_chk = 1'b0;
  logic        afe = 1'b0, xperm = 1'b0;
  logic [1:0]  rom_sys = '0;
  logic [31:0] dacr = '0;
  logic        tlb_hit = 1'b1;
  logic [3:0]  ent_dom = '0;
  logic [2:0]  ent_ap = '0;
  logic        ent_xn = 1'b0, ent_section = 1'b0, ent_nocache = 1'b0;
  logic [31:0] ent_paddr = 32'h8000_0000;
  logic        rsp_valid, rsp_fault, rsp_pabt, rsp_unpred, rsp_miss;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_access_checker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr), .kind(kind),
    .priv_mode(priv_mode), .user_req(user_req), .allow_unal(allow_unal),
    .align_mask(align_mask), .prefetch(prefetch), .mmu_en(mmu_en),
    .align_chk(align_chk), .afe(afe), .xperm(xperm), .rom_sys(rom_sys),
    .dacr(dacr), .tlb_hit(tlb_hit), .ent_dom(ent_dom), .ent_ap(ent_ap),
    .ent_xn(ent_xn), .ent_section(ent_section), .ent_nocache(ent_nocache),
    .ent_paddr(ent_paddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_pabt(rsp_pabt), .rsp_unpred(rsp_unpred),
    .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
  );

  // expected {fault, code, pabt, unpred, miss}
  function automatic logic [6:0] expect_verdict();
    logic fetch = (kind == 2'd2);
    logic wr    = (kind == 2'd1);
    logic pv    = priv_mode && !user_req;
    logic [2:0] ap;
    logic [1:0] fld;
    logic abt;
    if (!fetch && (align_chk || !allow_unal) && ((vaddr[2:0] & align_mask) != 0))
      return {1'b1, 3'd1, 3'b000};
    if (!mmu_en) return 7'd0;
    if (!tlb_hit) return prefetch ? {1'b1, 3'd6, 3'b100} : 7'b0000_001;
    if (prefetch && ent_nocache) return {1'b1, 3'd7, 3'b100};
    fld = 2'((dacr >> (ent_dom * 2)) & 32'd3);
    if (fld == 2'd0) return {1'b1, ent_section ? 3'd2 : 3'd3, fetch, 2'b00};
    if (fld == 2'd2) return 7'b0000_010;
    if (fld == 2'd3) return 7'd0;
    ap = ent_ap;
    if (afe) ap[0] = 1'b1;
    case (ap)
      3'd0: abt = xperm ? 1'b1 : (rom_sys == 2'd2) ? wr : (rom_sys == 2'd1) ? (wr || !pv) : 1'b1;
      3'd1: abt = !pv;
      3'd2: abt = !pv && wr;
      3'd3: abt = 1'b0;
      3'd4: return 7'b0000_010;
      3'd5: abt = !pv || wr;
      default: abt = wr;
    endcase
    if (abt || (fetch && ent_xn)) return {1'b1, ent_section ? 3'd4 : 3'd5, fetch, 2'b00};
    return 7'd0;
  endfunction

  task automatic check(input string req);
    logic [6:0]  exp;
    logic [31:0] exp_pa;
    exp    = expect_verdict();
    exp_pa = mmu_en ? ent_paddr : vaddr;
    req_valid = 1'b1;
    @(negedge clk);
    checks++;
    if ({rsp_fault, rsp_code, rsp_pabt, rsp_unpred, rsp_miss} !== exp || rsp_paddr !== exp_pa
        || rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: got f=%0b c=%0d p=%0b u=%0b m=%0b pa=%h v=%0b exp %b pa=%h",
               req, rsp_fault, rsp_code, rsp_pabt, rsp_unpred, rsp_miss, rsp_paddr,
               rsp_valid, exp, exp_pa);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b exp %0b", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1 reset valid", rsp_valid, 1'b0);
    check_bit("R1 reset fault", rsp_fault, 1'b0);
    check_bit("R1 reset code", |rsp_code, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1 idle valid", rsp_valid, 1'b0);

    // R10 R9 R11 R12 R13: full permission sweep in client domain 5
    dacr = 32'h0000_0400;
    ent_dom = 4'd5;
    for (int a = 0; a < 8; a++)
      for (int f = 0; f < 2; f++)
        for (int x = 0; x < 2; x++)
          for (int r = 0; r < 4; r++)
            for (int k = 0; k < 3; k++)
              for (int p = 0; p < 4; p++) begin
                ent_ap = 3'(a); afe = f[0]; xperm = x[0]; rom_sys = 2'(r);
                kind = 2'(k); priv_mode = p[1]; user_req = p[0];
                ent_xn = a[0] ^ r[0]; ent_section = x[0] ^ p[0];
                check("R10 R9 R11 R12 R13 perm sweep");
              end
    afe = 0; xperm = 0; rom_sys = 0; ent_xn = 0;

    // R6 R7 R8: every domain through every field value
    ent_ap = 3'd0;
    for (int d = 0; d < 16; d++)
      for (int v = 0; v < 4; v++)
        for (int k = 0; k < 3; k++) begin
          ent_dom = 4'(d);
          dacr = 32'hAAAA_AAAA ^ (32'(v ^ 2) << (2 * d));
          kind = 2'(k); ent_section = d[0]; ent_xn = 1'b1;
          priv_mode = 1'b0; user_req = 1'b1;
          check("R6 R7 R8 domain sweep");
        end
    ent_xn = 0; priv_mode = 1; user_req = 0;

    // R2 R3: alignment sweep with translation on and off
    dacr = 32'hFFFF_FFFF; ent_ap = 3'd3;
    for (int m = 0; m < 8; m++)
      for (int lo = 0; lo < 8; lo++)
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 3; k++) begin
            align_mask = 3'(m); vaddr = 32'h1234_5670 | 32'(lo);
            align_chk = c[0]; allow_unal = c[1]; kind = 2'(k);
            mmu_en = lo[0] ^ m[0];
            check("R2 R3 align sweep");
          end
    align_mask = 0; mmu_en = 1; allow_unal = 1; align_chk = 0;

    // R4 miss handling
    tlb_hit = 0;
    for (int k = 0; k < 4; k++) begin
      kind = 2'(k); prefetch = k[0];
      check("R4 miss");
    end
    tlb_hit = 1;

    // R5 prefetch on uncached entry outranks a blocking domain
    dacr = 32'h0; ent_nocache = 1; prefetch = 1; kind = 2'd0;
    check("R5 prefetch uncached");
    prefetch = 0;
    check("R5 non-prefetch uncached goes to domain");
    ent_nocache = 0;

    // R1 valid drops one cycle after request
    req_valid = 1'b0;
    @(negedge clk);
    check_bit("R1 valid low", rsp_valid, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule